// File: doc/BRIEF.md
# Transaction Nesting and Retry Controller

This controller sits beside one core's instruction sequencer and handles the begin and end instructions of hardware transactions. Begins that arrive while a transaction is already open are folded into it: a depth counter tracks the nesting, and only the end that brings the depth back to zero commits. On an abort, the whole flattened transaction is dropped, and a one-cycle redirect gives the address where execution restarts. For a normal transaction this is the instruction after the outermost begin, and a condition code tells software why it failed. For a constrained transaction it is the begin instruction itself, and the condition code is left unchanged.

Every abort counts as a retry. A successful commit clears the count. After each abort the core is stalled for a pseudo-random number of cycles, and the ceiling on that delay doubles with each retry up to a cap. When a constrained transaction keeps failing and its retry count reaches a threshold, the controller requests a broadcast that brings the other cores to a halt. It holds the request, and keeps the core stalled, until the grant arrives.

Top module: `txn_seq_ctrl`

## Requirements
- R1: Each begin while a transaction is open increments the nesting depth; `in_txn_o` stays 1 through every inner end.
- R2: The end that brings the depth from 1 to 0 commits: `in_txn_o` falls, `cc_o` becomes 2'b00, and the retry count is cleared.
- R3: An end with no open transaction changes no state other than setting `cc_o` to 2'b11.
- R4: An abort of a normal transaction raises `redirect_o` for exactly one cycle. `redirect_pc_o` is the outermost begin address plus INSN_BYTES (default 4). `cc_o` is 2'b01 when `abort_persist_i` is 0 and 2'b10 when it is 1.
- R5: An abort at any nesting depth ends the whole transaction: `in_txn_o` is 0 in the cycle after it.
- R6: An abort of a constrained transaction (outermost begin issued with `begin_cstr_i`=1) redirects to the outermost begin address and leaves `cc_o` unchanged.
- R7: After the abort that brings the retry count to n, `stall_o` stays high for at most 2^min(n,CAP)-1 cycles (CAP default 4), unless a broadcast is pending.
- R8: A constrained abort that brings the retry count to THRESH (default 4) or more raises `bcast_req_o` in the next cycle. The request and `stall_o` are held until `bcast_gnt_i` is sampled high, and the request is low in the cycle after that.
- R9: A commit resets the retry count, so the next constrained abort counts as retry 1 and raises no broadcast request.
- R10: An abort with no open transaction is ignored: there is no redirect and no stall.
- R11: A begin at depth MAX_DEPTH (default 4) is treated as a persistent abort, with redirect and condition code as in R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| begin_i | input | 1 | Begin instruction issued |
| begin_cstr_i | input | 1 | Begin is the constrained variant |
| begin_pc_i | input | AW | Address of the begin instruction |
| end_i | input | 1 | End instruction issued |
| abort_i | input | 1 | Abort event from the core or the cache |
| abort_persist_i | input | 1 | Abort cause is persistent (1) or transient (0) |
| bcast_gnt_i | input | 1 | Grant for the quiesce broadcast |
| in_txn_o | output | 1 | A transaction is open |
| redirect_o | output | 1 | One-cycle restart request |
| redirect_pc_o | output | AW | Restart address |
| cc_o | output | 2 | Condition code: 00 ok, 01 transient, 10 persistent, 11 unmatched end |
| stall_o | output | 1 | Hold the core (backoff or broadcast pending) |
| bcast_req_o | output | 1 | Request to quiesce all other cores |

## Verification
The nesting logic is exercised with a three-deep nest, an end that has no begin, and a nest pushed one level past its limit. These cases separate flattening from plain toggling, and they show that overflow is turned into an abort. Aborts are issued at depth two and at depth zero, in normal and constrained transactions, with both cause values. These cases tell the two restart targets apart, show which abort codes are kept or overwritten, and confirm that an abort outside a transaction is ignored. For the retry path, a run of constrained aborts is broken by a commit and then resumed. This shows whether the threshold is reached exactly at the fourth consecutive abort and not before, and whether a commit really clears the count. Each stall length is compared with the bound for its retry number.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;
  typedef enum logic [1:0] {
    CC_OK        = 2'b00,
    CC_TRANSIENT = 2'b01,
    CC_PERSIST   = 2'b10,
    CC_UNMATCHED = 2'b11
  } cc_e;
endpackage

// File: rtl/txn_nest_ctr.sv
module txn_nest_ctr #(
  parameter int MAX_DEPTH = 4,
  localparam int DW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          begin_i,
  input  logic          end_i,
  input  logic          kill_i,
  output logic [DW-1:0] depth_o,
  output logic          outer_o,
  output logic          commit_o,
  output logic          unmatched_o,
  output logic          overflow_o
);
  logic [DW-1:0] depth_q;
  logic idle, at_max;

  assign idle        = (depth_q == '0);
  assign at_max      = (depth_q == DW'(MAX_DEPTH));
  assign overflow_o  = begin_i & at_max;
  assign outer_o     = begin_i & idle & ~kill_i;
  assign commit_o    = end_i & ~begin_i & ~kill_i & (depth_q == DW'(1));
  assign unmatched_o = end_i & ~begin_i & idle;
  assign depth_o     = depth_q;

  // priority: kill > begin > end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      depth_q <= '0;
    else if (kill_i)                  depth_q <= '0;
    else if (begin_i)                 depth_q <= depth_q + DW'(1);
    else if (end_i && !idle)          depth_q <= depth_q - DW'(1);
  end

  assert_commit_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (depth_q == '0));
  assert_kill_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (depth_q == '0));
  assert_nest_inc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (begin_i && !kill_i) |=> (depth_q == $past(depth_q) + DW'(1)));
  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DW'(MAX_DEPTH));
endmodule

// File: rtl/txn_backoff.sv
module txn_backoff #(
  parameter int          RW     = 4,
  parameter int          CAP    = 4,
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [RW-1:0] retry_i,
  output logic          busy_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [CAP-1:0]    cnt_q, mask;
  logic [RW-1:0]     bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED[LFSR_W-1:0];
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS[LFSR_W-1:0])};
  end

  assign bits = (retry_i >= RW'(CAP)) ? RW'(CAP) : retry_i;

  // ceiling mask widens one bit per retry
  for (genvar k = 0; k < CAP; k++) begin : g_mask
    assign mask[k] = (bits > RW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= lfsr_q[CAP-1:0] & mask;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CAP'(1);
  end

  assign busy_o = (cnt_q != '0);

  assert_backoff_countdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CAP'(1)));
  assert_backoff_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((cnt_q & ~$past(mask)) == '0));
endmodule

// File: rtl/txn_escalate.sv
module txn_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic gnt_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (trig_i)  req_q <= 1'b1;
    else if (gnt_i)   req_q <= 1'b0;
  end

  assign req_o = req_q;

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !gnt_i && !trig_i) |=> req_q);
  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && gnt_i && !trig_i) |=> !req_q);
  assert_req_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(trig_i));
endmodule

// File: rtl/txn_seq_ctrl.sv
module txn_seq_ctrl
  import txn_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MAX_DEPTH  = 4,
  parameter int RW         = 4,
  parameter int CAP        = 4,
  parameter int THRESH     = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          begin_i,
  input  logic          begin_cstr_i,
  input  logic [AW-1:0] begin_pc_i,
  input  logic          end_i,
  input  logic          abort_i,
  input  logic          abort_persist_i,
  input  logic          bcast_gnt_i,
  output logic          in_txn_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic [1:0]    cc_o,
  output logic          stall_o,
  output logic          bcast_req_o
);
  localparam int DW = $clog2(MAX_DEPTH + 1);

  logic [DW-1:0] depth;
  logic outer, commit, unmatched, overflow;
  logic open_abort, kill, persist, busy;
  logic [RW-1:0] retry_q, retry_nxt;
  logic [AW-1:0] pc_q, redir_pc_q;
  logic cstr_q, redir_q;
  cc_e  cc_q;

  assign open_abort = abort_i & (depth != '0);
  assign kill       = open_abort | overflow;
  assign persist    = open_abort ? abort_persist_i : 1'b1;
  assign retry_nxt  = (&retry_q) ? retry_q : retry_q + RW'(1);

  txn_nest_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_nest (
    .clk_i, .rst_ni,
    .begin_i, .end_i, .kill_i(kill),
    .depth_o(depth), .outer_o(outer), .commit_o(commit),
    .unmatched_o(unmatched), .overflow_o(overflow)
  );

  txn_backoff #(.RW(RW), .CAP(CAP)) u_backoff (
    .clk_i, .rst_ni,
    .load_i(kill), .retry_i(retry_nxt), .busy_o(busy)
  );

  txn_escalate u_esc (
    .clk_i, .rst_ni,
    .trig_i(kill & cstr_q & (retry_nxt >= RW'(THRESH))),
    .gnt_i(bcast_gnt_i), .req_o(bcast_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      cstr_q <= 1'b0;
    end else if (outer) begin
      pc_q   <= begin_pc_i;
      cstr_q <= begin_cstr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      cc_q       <= CC_OK;
      retry_q    <= '0;
    end else begin
      redir_q <= kill;
      if (kill) begin
        redir_pc_q <= cstr_q ? pc_q : pc_q + AW'(INSN_BYTES);
        retry_q    <= retry_nxt;
        if (!cstr_q) cc_q <= persist ? CC_PERSIST : CC_TRANSIENT;
      end else if (commit) begin
        cc_q    <= CC_OK;
        retry_q <= '0;
      end else if (unmatched) begin
        cc_q <= CC_UNMATCHED;
      end
    end
  end

  assign in_txn_o      = (depth != '0);
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;
  assign cc_o          = cc_q;
  assign stall_o       = busy | bcast_req_o;

  assert_redirect_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
  assert_unmatched_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unmatched && !kill) |=> (cc_o == CC_UNMATCHED));
  assert_cstr_keeps_cc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill && cstr_q) |=> $stable(cc_o));
  assert_commit_clears_retry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !kill) |=> (retry_q == '0));
  assert_idle_abort_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !in_txn_o && !begin_i) |=> !redirect_o);
endmodule

// File: tb/txn_seq_ctrl_tb.sv
module txn_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic begin_s = 0, cstr_s = 0, end_s = 0, abort_s = 0, persist_s = 0, gnt_s = 0;
  logic [31:0] pc_s = '0;
  logic in_txn, redir, stall, breq;
  logic [31:0] redir_pc;
  logic [1:0] cc;
  int checks = 0, errors = 0;
  int nretry = 0;

  always #5 clk = ~clk;

  txn_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .begin_i(begin_s), .begin_cstr_i(cstr_s), .begin_pc_i(pc_s),
    .end_i(end_s), .abort_i(abort_s), .abort_persist_i(persist_s),
    .bcast_gnt_i(gnt_s),
    .in_txn_o(in_txn), .redirect_o(redir), .redirect_pc_o(redir_pc),
    .cc_o(cc), .stall_o(stall), .bcast_req_o(breq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_le(input string req, input string what, input int act, input int lim);
    checks++;
    if (act > lim) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected <= %0d", req, what, act, lim);
    end
  endtask

  // drive one cycle of inputs, return at the negedge after the capturing edge
  task automatic issue(input logic b, input logic c, input logic [31:0] pc,
                       input logic e, input logic a, input logic p);
    begin_s = b; cstr_s = c; pc_s = pc; end_s = e; abort_s = a; persist_s = p;
    @(negedge clk);
    begin_s = 0; cstr_s = 0; end_s = 0; abort_s = 0; persist_s = 0;
  endtask

  task automatic wait_backoff(input string req, input int n);
    int len = 0;
    int lim = (1 << ((n > 4) ? 4 : n)) - 1;
    while (stall) begin len++; @(negedge clk); end
    chk_le(req, "stall length", len, lim);
  endtask

  task automatic commit_one();
    issue(1, 0, 32'h10, 0, 0, 0);
    issue(0, 0, 0, 1, 0, 0);
    nretry = 0;
  endtask

  task automatic t_reset();
    chk("R2", "reset in_txn", in_txn, 0);
    chk("R2", "reset cc", cc, 0);
    chk("R10", "reset redirect", redir, 0);
    chk("R8", "reset stall/bcast", {stall, breq}, 0);
  endtask

  task automatic t_nest();
    issue(1, 0, 32'h100, 0, 0, 0);
    issue(1, 0, 32'h180, 0, 0, 0);
    issue(1, 1, 32'h1C0, 0, 0, 0);
    chk("R1", "in_txn depth3", in_txn, 1);
    issue(0, 0, 0, 1, 0, 0);
    issue(0, 0, 0, 1, 0, 0);
    chk("R1", "in_txn after inner ends", in_txn, 1);
    issue(0, 0, 0, 1, 0, 0);
    chk("R2", "in_txn after outer end", in_txn, 0);
    chk("R2", "cc after commit", cc, 0);
  endtask

  task automatic t_unmatched();
    issue(0, 0, 0, 1, 0, 0);
    chk("R3", "cc unmatched", cc, 3);
    chk("R3", "in_txn unmatched", in_txn, 0);
    chk("R3", "no redirect", redir, 0);
    commit_one();
    chk("R2", "cc restored", cc, 0);
  endtask

  task automatic t_normal_abort();
    issue(1, 0, 32'h200, 0, 0, 0);
    issue(1, 0, 32'h240, 0, 0, 0);
    issue(0, 0, 0, 0, 1, 0);
    nretry++;
    chk("R4", "redirect", redir, 1);
    chk("R4", "redirect pc", redir_pc, 32'h204);
    chk("R4", "cc transient", cc, 1);
    chk("R5", "in_txn after abort at depth2", in_txn, 0);
    @(negedge clk);
    chk("R4", "redirect one cycle", redir, 0);
    wait_backoff("R7", nretry);
    issue(1, 0, 32'h300, 0, 0, 0);
    issue(0, 0, 0, 0, 1, 1);
    nretry++;
    chk("R4", "redirect pc 2", redir_pc, 32'h304);
    chk("R4", "cc persistent", cc, 2);
    wait_backoff("R7", nretry);
    commit_one();
  endtask

  task automatic t_cstr_abort();
    issue(1, 1, 32'h400, 0, 0, 0);
    issue(1, 0, 32'h440, 0, 0, 0);
    issue(0, 0, 0, 0, 1, 1);
    nretry++;
    chk("R6", "redirect", redir, 1);
    chk("R6", "redirect pc", redir_pc, 32'h400);
    chk("R6", "cc unchanged", cc, 0);
    chk("R5", "in_txn", in_txn, 0);
    wait_backoff("R7", nretry);
    commit_one();
  endtask

  task automatic t_idle_abort();
    issue(0, 0, 0, 0, 1, 1);
    chk("R10", "no redirect", redir, 0);
    chk("R10", "no stall", stall, 0);
    chk("R10", "cc kept", cc, 0);
    chk("R10", "in_txn", in_txn, 0);
  endtask

  task automatic cstr_fail(input int pc);
    issue(1, 1, pc, 0, 0, 0);
    issue(0, 0, 0, 0, 1, 0);
    nretry++;
  endtask

  task automatic t_bcast();
    for (int i = 0; i < 3; i++) begin
      cstr_fail(32'h600);
      chk("R8", "no bcast below threshold", breq, 0);
      wait_backoff("R7", nretry);
    end
    commit_one();
    cstr_fail(32'h700);
    chk("R9", "no bcast after commit reset", breq, 0);
    wait_backoff("R7", nretry);
    for (int i = 0; i < 2; i++) begin
      cstr_fail(32'h700);
      chk("R9", "no bcast at retry below threshold", breq, 0);
      wait_backoff("R7", nretry);
    end
    cstr_fail(32'h700);
    chk("R8", "bcast at threshold", breq, 1);
    chk("R8", "redirect at threshold", redir_pc, 32'h700);
    repeat (20) @(negedge clk);
    chk("R8", "bcast held", breq, 1);
    chk("R8", "stall held", stall, 1);
    gnt_s = 1;
    @(negedge clk);
    gnt_s = 0;
    chk("R8", "bcast dropped after grant", breq, 0);
    chk("R8", "stall released", stall, 0);
    commit_one();
  endtask

  task automatic t_overflow();
    issue(1, 0, 32'h500, 0, 0, 0);
    for (int i = 0; i < 3; i++) issue(1, 0, 32'h580, 0, 0, 0);
    chk("R11", "in_txn at max depth", in_txn, 1);
    chk("R11", "no redirect at max", redir, 0);
    issue(1, 0, 32'h5C0, 0, 0, 0);
    nretry++;
    chk("R11", "redirect on overflow", redir, 1);
    chk("R11", "overflow redirect pc", redir_pc, 32'h504);
    chk("R11", "overflow cc persistent", cc, 2);
    chk("R11", "in_txn after overflow", in_txn, 0);
    wait_backoff("R7", nretry);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nest();
    t_unmatched();
    t_normal_abort();
    t_cstr_abort();
    t_idle_abort();
    t_bcast();
    t_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule